// File: doc/BRIEF.md
# Privilege State Register

This block keeps the privilege bookkeeping of a processor core in one small control and status register. It holds the level of the code that is executing now (the current field), the level to restore when the running exception handler returns (the saved field), an interrupt-enable bit, and a saved copy of that bit. Hardware strobes for exception entry and exception return move these values between the live and saved slots. Software reaches the saved field through a CSR read/write port.

The current field cannot be written by software. It changes only on exception entry, which always enters supervisor level 3, and on exception return, which restores the saved field. A supervisor handler may load any level into the saved field and then return, which is how code drops to a lower level. Code below supervisor may only lower the saved field. The current level also drives two dedicated pins, so an external memory-protection unit can check each access against it. A single exception level is assumed, with no nesting.

Top module: `priv_state_csr`

## Requirements
- R1: After reset the current and saved privilege fields both hold level 3 (supervisor), and the interrupt-enable bit and its saved copy are 0.
- R2: A read at CSR address 0x00B returns the current field in bits [1:0], the saved field in bits [3:2], and zero in bits [31:4]. A read at any other address returns zero, and a write at any other address changes nothing.
- R3: A CSR write never changes the current field. Bits [1:0] of the write data are ignored.
- R4: When the current field is 3, a write at 0x00B loads bits [3:2] of the write data into the saved field, whatever the value, including a raise to 3.
- R5: When the current field is below 3, a write at 0x00B updates the saved field only if bits [3:2] are strictly lower than the stored value. Otherwise the saved field keeps its value.
- R6: On an exception-entry strobe the design does all of the following at one clock edge: it copies the current field into the saved field, sets the current field to 3, copies the interrupt-enable bit into its saved copy, and clears the interrupt-enable bit.
- R7: On an exception-return strobe the design copies the saved field into the current field and the saved interrupt-enable copy into the interrupt-enable bit. The saved field and the saved copy do not change.
- R8: When entry and return are strobed in the same cycle, entry takes effect and return is ignored.
- R9: When an entry or return strobe arrives in the same cycle as a CSR write or an interrupt-enable write, the hardware event takes effect and the write is discarded.
- R10: The two privilege output pins always equal the current field.
- R11: When the interrupt-enable write strobe is high and no hardware event is present, the interrupt-enable bit takes the write value at the clock edge. Its saved copy does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | ADDR_W (12) | CSR address for read and write |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | DATA_W (32) | CSR write data |
| csr_rdata | output | DATA_W (32) | CSR read data, combinational from the address |
| exc_enter | input | 1 | Exception-entry strobe |
| exc_return | input | 1 | Return-from-exception strobe |
| ie_we | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 1 | Interrupt-enable write value |
| cur_priv | output | 2 | Current privilege level for external protection logic |
| irq_en | output | 1 | Interrupt-enable bit |
| irq_en_saved | output | 1 | Saved copy of the interrupt-enable bit |

## Verification
The bench targets the following corner cases, and names what a faulty design would show in each:
- A write that raises the saved field from a user level must be ignored. A design that compared with the wrong sense would let user code grant itself supervisor level on the next return.
- A raise written while in supervisor must be accepted. A design that applied the lower-only rule everywhere could never return to supervisor after one drop.
- Entry, return and a write in the same cycle: a wrong priority order would show a restored level instead of 3, or a saved field overwritten by software during entry.
- Every write also sets bits [1:0] and the unused bits to ones. Any leak into the current field or into the read-back upper bits shows at the pins.

// File: rtl/priv_pkg.sv
package priv_pkg;

    localparam int PRIV_W   = 2;
    localparam int CUR_LSB  = 0;
    localparam int SAVE_LSB = CUR_LSB + PRIV_W;
    localparam int FIELDS_W = 2 * PRIV_W;

    typedef logic [PRIV_W-1:0] priv_t;

    localparam priv_t PRIV_SUPER = '1;
    localparam priv_t PRIV_USER  = '0;

    typedef struct packed {
        priv_t cur;
        priv_t saved;
        logic  ie;
        logic  ie_saved;
    } priv_state_t;

    localparam priv_state_t PRIV_STATE_RESET = '{
        cur:      PRIV_SUPER,
        saved:    PRIV_SUPER,
        ie:       1'b0,
        ie_saved: 1'b0
    };

endpackage

// File: rtl/priv_csr_port.sv
module priv_csr_port
    import priv_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h00B
) (
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] csr_wdata,
    input  priv_t             cur_q,
    input  priv_t             saved_q,
    output logic              hit_we,
    output priv_t             wr_saved,
    output logic [DATA_W-1:0] csr_rdata
);

    logic addr_hit;

    assign addr_hit = (csr_addr == CSR_ADDR);
    assign hit_we   = addr_hit && csr_we;
    assign wr_saved = csr_wdata[SAVE_LSB +: PRIV_W];

    always_comb begin
        csr_rdata = '0;
        if (addr_hit) begin
            csr_rdata[CUR_LSB  +: PRIV_W] = cur_q;
            csr_rdata[SAVE_LSB +: PRIV_W] = saved_q;
        end
    end

endmodule

// File: rtl/priv_save_filter.sv
module priv_save_filter
    import priv_pkg::*;
(
    input  priv_t cur_q,
    input  priv_t saved_q,
    input  priv_t req,
    output logic  accept
);

    logic is_super;
    logic lowers;

    assign is_super = (cur_q == PRIV_SUPER);
    assign lowers   = (req < saved_q);
    assign accept   = is_super || lowers;

endmodule

// File: rtl/priv_state_core.sv
module priv_state_core
    import priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exc_enter,
    input  logic        exc_return,
    input  logic        wr_hit,
    input  logic        wr_accept,
    input  priv_t       wr_saved,
    input  logic        ie_we,
    input  logic        ie_wdata,
    output priv_state_t state_q
);

    priv_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (exc_enter) begin
            state_d.saved    = state_q.cur;
            state_d.cur      = PRIV_SUPER;
            state_d.ie_saved = state_q.ie;
            state_d.ie       = 1'b0;
        end else if (exc_return) begin
            state_d.cur = state_q.saved;
            state_d.ie  = state_q.ie_saved;
        end else begin
            if (wr_hit && wr_accept) begin
                state_d.saved = wr_saved;
            end
            if (ie_we) begin
                state_d.ie = ie_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PRIV_STATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/priv_state_csr.sv
module priv_state_csr
    import priv_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h00B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic              csr_we,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic              exc_enter,
    input  logic              exc_return,
    input  logic              ie_we,
    input  logic              ie_wdata,
    output logic [1:0]        cur_priv,
    output logic              irq_en,
    output logic              irq_en_saved
);

    priv_state_t state_q;
    priv_t       saved_q;
    priv_t       wr_saved;
    logic        wr_hit;
    logic        wr_accept;

    assign saved_q = state_q.saved;

    priv_csr_port #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .CSR_ADDR (CSR_ADDR)
    ) u_port (
        .csr_addr  (csr_addr),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .cur_q     (state_q.cur),
        .saved_q   (saved_q),
        .hit_we    (wr_hit),
        .wr_saved  (wr_saved),
        .csr_rdata (csr_rdata)
    );

    priv_save_filter u_filter (
        .cur_q   (state_q.cur),
        .saved_q (saved_q),
        .req     (wr_saved),
        .accept  (wr_accept)
    );

    priv_state_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_enter  (exc_enter),
        .exc_return (exc_return),
        .wr_hit     (wr_hit),
        .wr_accept  (wr_accept),
        .wr_saved   (wr_saved),
        .ie_we      (ie_we),
        .ie_wdata   (ie_wdata),
        .state_q    (state_q)
    );

    assign cur_priv     = state_q.cur;
    assign irq_en       = state_q.ie;
    assign irq_en_saved = state_q.ie_saved;

endmodule

// File: rtl/priv_state_csr_chk.sv
module priv_state_csr_chk #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h00B
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] csr_addr,
    input logic              csr_we,
    input logic [DATA_W-1:0] csr_wdata,
    input logic [DATA_W-1:0] csr_rdata,
    input logic              exc_enter,
    input logic              exc_return,
    input logic              ie_we,
    input logic [1:0]        cur_priv,
    input logic              irq_en,
    input logic              irq_en_saved,
    input logic [1:0]        saved_q
);

    logic wr_hit;
    assign wr_hit = csr_we && (csr_addr == CSR_ADDR);

    AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> cur_priv == 2'b11); // R6

    AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
        exc_enter |=> (saved_q == $past(cur_priv)) && (irq_en_saved == $past(irq_en)) && !irq_en); // R6

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !exc_enter) |=> (cur_priv == $past(saved_q)) && (irq_en == $past(irq_en_saved))); // R7

    AST_CUR_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_enter && !exc_return) |=> $stable(cur_priv)); // R3

    AST_NO_USER_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !exc_enter && !exc_return && cur_priv != 2'b11 && csr_wdata[3:2] >= saved_q)
        |=> $stable(saved_q)); // R5

    AST_ENTRY_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && exc_return) |=> !irq_en && cur_priv == 2'b11); // R8

    AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && wr_hit) |=> saved_q == $past(cur_priv)); // R9

    AST_IE_WRITE_KEEPS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_we && !exc_enter) |=> $stable(irq_en_saved)); // R11

    AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[DATA_W-1:4] == '0); // R2

    AST_PINS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == CSR_ADDR) |-> csr_rdata[1:0] == cur_priv); // R10

endmodule

bind priv_state_csr priv_state_csr_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_addr     (csr_addr),
    .csr_we       (csr_we),
    .csr_wdata    (csr_wdata),
    .csr_rdata    (csr_rdata),
    .exc_enter    (exc_enter),
    .exc_return   (exc_return),
    .ie_we        (ie_we),
    .cur_priv     (cur_priv),
    .irq_en       (irq_en),
    .irq_en_saved (irq_en_saved),
    .saved_q      (saved_q)
);

// File: tb/priv_state_csr_bench.sv
`timescale 1ns/100ps
module priv_state_csr_bench;

    localparam int          DATA_W   = 32;
    localparam int          ADDR_W   = 12;
    localparam logic [11:0] CSR_ADDR = 12'h00B;
    localparam int          NVEC     = 20;

    // {enter, return, we, addr_hit, wr_saved[1:0], ie_we, ie_val,
    //  exp_cur[1:0], exp_saved[1:0], exp_ie, exp_ie_saved}
    localparam logic [13:0] VEC [NVEC] = '{
        14'b0000_00_11_11_11_10,
        14'b1000_00_00_11_11_01,
        14'b0011_00_00_11_00_01,
        14'b0100_00_00_00_00_11,
        14'b0011_11_00_00_00_11,
        14'b1000_00_00_11_00_01,
        14'b0011_10_00_11_10_01,
        14'b0100_00_00_10_10_11,
        14'b0011_11_00_10_10_11,
        14'b0011_01_00_10_01_11,
        14'b0010_00_00_10_01_11,
        14'b1100_00_00_11_10_01,
        14'b1011_00_00_11_11_00,
        14'b0100_00_11_11_11_00,
        14'b0011_01_00_11_01_00,
        14'b0100_00_00_01_01_00,
        14'b0011_00_00_01_00_00,
        14'b0011_01_00_01_00_00,
        14'b0000_00_11_01_00_10,
        14'b0000_00_10_01_00_00
    };

    function automatic string tag_of(int i);
        case (i)
            0, 18, 19:      tag_of = "R11";
            1, 5:           tag_of = "R6";
            2, 6, 14:       tag_of = "R4 R3";
            3, 7, 15:       tag_of = "R7";
            4, 8, 16, 17:   tag_of = "R5 R3";
            9:              tag_of = "R5";
            10:             tag_of = "R2";
            11:             tag_of = "R8";
            default:        tag_of = "R9";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] csr_addr = CSR_ADDR;
    logic              csr_we = 1'b0;
    logic [DATA_W-1:0] csr_wdata = '0;
    logic [DATA_W-1:0] csr_rdata;
    logic              exc_enter = 1'b0;
    logic              exc_return = 1'b0;
    logic              ie_we = 1'b0;
    logic              ie_wdata = 1'b0;
    logic [1:0]        cur_priv;
    logic              irq_en;
    logic              irq_en_saved;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    priv_state_csr u_priv_state_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .csr_addr     (csr_addr),
        .csr_we       (csr_we),
        .csr_wdata    (csr_wdata),
        .csr_rdata    (csr_rdata),
        .exc_enter    (exc_enter),
        .exc_return   (exc_return),
        .ie_we        (ie_we),
        .ie_wdata     (ie_wdata),
        .cur_priv     (cur_priv),
        .irq_en       (irq_en),
        .irq_en_saved (irq_en_saved)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        csr_addr   = CSR_ADDR;
        csr_we     = 1'b0;
        csr_wdata  = '0;
        exc_enter  = 1'b0;
        exc_return = 1'b0;
        ie_we      = 1'b0;
        ie_wdata   = 1'b0;
    endtask

    function automatic logic [5:0] observed();
        return {cur_priv, csr_rdata[3:2], irq_en, irq_en_saved};
    endfunction

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1: reset state, read back at the register address
        check("R1 read", csr_rdata, 32'h0000_000F);
        check("R1 state", {26'd0, observed()}, {26'd0, 6'b11_11_00});
        check("R10 pins", {30'd0, cur_priv}, {30'd0, 2'b11});
        csr_addr = CSR_ADDR ^ 12'h001;
        #0.5;
        check("R2 other address reads zero", csr_rdata, 32'h0);
        csr_addr = CSR_ADDR;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            exc_enter  = VEC[i][13];
            exc_return = VEC[i][12];
            csr_we     = VEC[i][11];
            csr_addr   = VEC[i][10] ? CSR_ADDR : (CSR_ADDR ^ 12'h001);
            csr_wdata  = {28'hFFF_FFFF, VEC[i][9:8], 2'b11};
            ie_we      = VEC[i][7];
            ie_wdata   = VEC[i][6];
            @(posedge clk);
            #1;
            idle_inputs();
            #0.5;
            check(tag_of(i), {26'd0, observed()}, {26'd0, VEC[i][5:0]});
            check("R2 upper zero", {4'd0, csr_rdata[31:4]}, 32'h0);
            check("R10 pins", {30'd0, cur_priv}, {30'd0, csr_rdata[1:0]});
        end

        // R1: reset during operation returns to supervisor everywhere
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        #0.5;
        check("R1 mid-run reset", {26'd0, observed()}, {26'd0, 6'b11_11_00});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule